// File: doc/BRIEF.md
# ALU Operation Decoder

This block turns the instruction fields of a 32-bit integer core into the 4-bit operation code that steers the ALU. It takes a 2-bit class from the main control, a flag that marks register-immediate arithmetic, the 7-bit funct7 field and the 3-bit funct3 field. The output is purely combinational, so it is valid in the same cycle as its inputs.

Class 01 is the address class. It forces an add for loads and stores, whatever the function fields hold. Every other class decodes the function fields. With the immediate flag clear, funct7 must be one of the two legal patterns. With the flag set, funct7 holds immediate bits, so only its bit 5 counts, and only for right shifts. Any field combination that is not recognised yields the invalid code 1111.

Top module: `alu_ctl`

## Requirements
- R1: When alu_class_i is 01, alu_op_o is 0010 (add), regardless of imm_i, funct7_i and funct3_i.
- R2: With the function fields decoded and funct7_i = 0000000, funct3_i maps as follows: 001 gives 1001 (sll), 010 gives 1000 (slt), 011 gives 0101 (sltu), 100 gives 0110 (xor), 110 gives 0001 (or) and 111 gives 0000 (and).
- R3: With imm_i = 0 and funct3_i = 000, funct7_i = 0000000 gives 0010 (add) and funct7_i = 0100000 gives 0011 (sub).
- R4: With imm_i = 0 and funct3_i = 101, funct7_i = 0000000 gives 0111 (srl) and funct7_i = 0100000 gives 0100 (sra).
- R5: With imm_i = 0 and a decoded class, alu_op_o is 1111 when funct7_i is neither 0000000 nor 0100000, and also when funct7_i = 0100000 is paired with a funct3_i other than 000 or 101.
- R6: With imm_i = 1 and funct3_i other than 101, funct7_i has no effect. funct3_i = 000 gives 0010 (add), and the other values follow the R2 map.
- R7: With imm_i = 1 and funct3_i = 101, funct7_i bit 5 alone selects the shift: 0 gives 0111 (srl) and 1 gives 0100 (sra).
- R8: alu_class_i values 10 and 11 decode exactly as 00 does.
- R9: alu_op_o only ever takes one of the ten operation codes 0000 to 1001 or the invalid code 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_class_i | input | 2 | Operation class from the main control; 01 forces add |
| imm_i | input | 1 | Register-immediate arithmetic flag |
| funct7_i | input | 7 | Instruction bits 31..25 |
| funct3_i | input | 3 | Instruction bits 14..12 |
| alu_op_o | output | 4 | ALU operation code, 1111 when the input is not recognised |

## Verification
The block holds no state, so an internal decoding error shows up at alu_op_o in the same cycle the offending fields are applied. The bench samples half a clock after each change. The errors most likely to hide are in the funct7 qualification: a sub or sra that leaks into the immediate path, an alternate funct7 pattern accepted beside a non-shift funct3, or an address class that is not forced to add. These are targeted by table vectors, and then caught broadly by a sweep over every input combination compared against a model built from the requirements.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;
  localparam int CLS_W = 2;
  localparam int F7_W  = 7;
  localparam int F3_W  = 3;
  localparam int OP_W  = 4;
  localparam int ALT_BIT = 5;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0011,
    OP_SRA  = 4'b0100,
    OP_SLTU = 4'b0101,
    OP_XOR  = 4'b0110,
    OP_SRL  = 4'b0111,
    OP_SLT  = 4'b1000,
    OP_SLL  = 4'b1001,
    OP_BAD  = 4'b1111
  } alu_op_e;

  localparam logic [CLS_W-1:0] CLS_ADDR = 2'b01;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  localparam logic [F3_W-1:0] F3_ADD  = 3'b000;
  localparam logic [F3_W-1:0] F3_SLL  = 3'b001;
  localparam logic [F3_W-1:0] F3_SLT  = 3'b010;
  localparam logic [F3_W-1:0] F3_SLTU = 3'b011;
  localparam logic [F3_W-1:0] F3_XOR  = 3'b100;
  localparam logic [F3_W-1:0] F3_SHR  = 3'b101;
  localparam logic [F3_W-1:0] F3_OR   = 3'b110;
  localparam logic [F3_W-1:0] F3_AND  = 3'b111;
endpackage

// File: rtl/alu_ctl_f7_qual.sv
// Qualifies funct7: legality and the alternate-variant select bits.
module alu_ctl_f7_qual
  import alu_ctl_pkg::*;
(
  input  logic            imm_i,
  input  logic [F7_W-1:0] funct7_i,
  input  logic [F3_W-1:0] funct3_i,
  output logic            legal_o,
  output logic            sub_o,
  output logic            sra_o
);
  logic is_base, is_alt, alt_ok;

  always_comb begin
    is_base = (funct7_i == F7_BASE);
    is_alt  = (funct7_i == F7_ALT);
    alt_ok  = (funct3_i == F3_ADD) || (funct3_i == F3_SHR);
    // immediate forms carry imm bits in funct7, so anything is legal
    legal_o = imm_i || is_base || (is_alt && alt_ok);
    sub_o   = !imm_i && is_alt;
    sra_o   = funct7_i[ALT_BIT];
  end
endmodule

// File: rtl/alu_ctl_f3_dec.sv
module alu_ctl_f3_dec
  import alu_ctl_pkg::*;
(
  input  logic [F3_W-1:0] funct3_i,
  input  logic            sub_i,
  input  logic            sra_i,
  output alu_op_e         op_o
);
  always_comb begin
    unique case (funct3_i)
      F3_ADD:  op_o = sub_i ? OP_SUB : OP_ADD;
      F3_SLL:  op_o = OP_SLL;
      F3_SLT:  op_o = OP_SLT;
      F3_SLTU: op_o = OP_SLTU;
      F3_XOR:  op_o = OP_XOR;
      F3_SHR:  op_o = sra_i ? OP_SRA : OP_SRL;
      F3_OR:   op_o = OP_OR;
      F3_AND:  op_o = OP_AND;
      default: op_o = OP_BAD;
    endcase
  end
endmodule

// File: rtl/alu_ctl_cls_sel.sv
// Final select: address class wins, then legality, then decoded op.
module alu_ctl_cls_sel
  import alu_ctl_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  logic             legal_i,
  input  alu_op_e          dec_op_i,
  output alu_op_e          op_o
);
  always_comb begin
    if (cls_i == CLS_ADDR)  op_o = OP_ADD;
    else if (!legal_i)      op_o = OP_BAD;
    else                    op_o = dec_op_i;
  end
endmodule

// File: rtl/alu_ctl.sv
module alu_ctl
  import alu_ctl_pkg::*;
(
  input  logic [CLS_W-1:0] alu_class_i,
  input  logic             imm_i,
  input  logic [F7_W-1:0]  funct7_i,
  input  logic [F3_W-1:0]  funct3_i,
  output logic [OP_W-1:0]  alu_op_o
);
  logic    legal, sub_sel, sra_sel;
  alu_op_e dec_op, fin_op;

  alu_ctl_f7_qual u_f7_qual (
    .imm_i    (imm_i),
    .funct7_i (funct7_i),
    .funct3_i (funct3_i),
    .legal_o  (legal),
    .sub_o    (sub_sel),
    .sra_o    (sra_sel)
  );

  alu_ctl_f3_dec u_f3_dec (
    .funct3_i (funct3_i),
    .sub_i    (sub_sel),
    .sra_i    (sra_sel),
    .op_o     (dec_op)
  );

  alu_ctl_cls_sel u_cls_sel (
    .cls_i    (alu_class_i),
    .legal_i  (legal),
    .dec_op_i (dec_op),
    .op_o     (fin_op)
  );

  assign alu_op_o = fin_op;

  always_comb begin
    // R1
    forced_add_chk: assert (alu_class_i != CLS_ADDR || alu_op_o == OP_ADD)
      else $error("address class not forced to add");
    // R9
    code_range_chk: assert (alu_op_o <= OP_SLL || alu_op_o == OP_BAD)
      else $error("reserved op code on output");
    // R3
    sub_src_chk: assert (alu_op_o != OP_SUB ||
                         (!imm_i && funct3_i == F3_ADD && funct7_i == F7_ALT))
      else $error("sub from wrong fields");
    // R4
    sra_src_chk: assert (alu_op_o != OP_SRA ||
                         (funct3_i == F3_SHR && funct7_i[ALT_BIT]))
      else $error("sra from wrong fields");
    // R5
    bad_src_chk: assert (alu_op_o != OP_BAD ||
                         (!imm_i && alu_class_i != CLS_ADDR))
      else $error("invalid code outside register form");
    // R6
    imm_add_chk: assert (!(imm_i && alu_class_i != CLS_ADDR && funct3_i == F3_ADD) ||
                         alu_op_o == OP_ADD)
      else $error("immediate add not decoded");
  end
endmodule

// File: tb/alu_ctl_bench.sv
module alu_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cls;
  logic       imm;
  logic [6:0] f7;
  logic [2:0] f3;
  logic [3:0] op;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_ctl u_alu_ctl (
    .alu_class_i (cls),
    .imm_i       (imm),
    .funct7_i    (f7),
    .funct3_i    (f3),
    .alu_op_o    (op)
  );

  typedef struct packed {
    logic [1:0] c;
    logic       i;
    logic [6:0] s7;
    logic [2:0] s3;
    logic [3:0] e;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 7'h00, 3'b000, 4'b0010},  // R3 add
    '{2'b00, 1'b0, 7'h20, 3'b000, 4'b0011},  // R3 sub
    '{2'b00, 1'b0, 7'h00, 3'b001, 4'b1001},  // R2 sll
    '{2'b00, 1'b0, 7'h00, 3'b010, 4'b1000},  // R2 slt
    '{2'b00, 1'b0, 7'h00, 3'b011, 4'b0101},  // R2 sltu
    '{2'b00, 1'b0, 7'h00, 3'b100, 4'b0110},  // R2 xor
    '{2'b00, 1'b0, 7'h00, 3'b101, 4'b0111},  // R4 srl
    '{2'b00, 1'b0, 7'h20, 3'b101, 4'b0100},  // R4 sra
    '{2'b00, 1'b0, 7'h00, 3'b110, 4'b0001},  // R2 or
    '{2'b00, 1'b0, 7'h00, 3'b111, 4'b0000},  // R2 and
    '{2'b01, 1'b0, 7'h7f, 3'b101, 4'b0010},  // R1
    '{2'b01, 1'b1, 7'h20, 3'b000, 4'b0010},  // R1
    '{2'b01, 1'b0, 7'h01, 3'b011, 4'b0010},  // R1
    '{2'b00, 1'b0, 7'h01, 3'b000, 4'b1111},  // R5
    '{2'b00, 1'b0, 7'h20, 3'b001, 4'b1111},  // R5
    '{2'b00, 1'b0, 7'h60, 3'b101, 4'b1111},  // R5
    '{2'b00, 1'b0, 7'h20, 3'b111, 4'b1111},  // R5
    '{2'b00, 1'b1, 7'h20, 3'b000, 4'b0010},  // R6
    '{2'b00, 1'b1, 7'h5a, 3'b111, 4'b0000},  // R6
    '{2'b00, 1'b1, 7'h7f, 3'b010, 4'b1000},  // R6
    '{2'b00, 1'b1, 7'h20, 3'b101, 4'b0100},  // R7
    '{2'b00, 1'b1, 7'h5f, 3'b101, 4'b0111},  // R7
    '{2'b00, 1'b1, 7'h3f, 3'b101, 4'b0100},  // R7
    '{2'b10, 1'b0, 7'h20, 3'b000, 4'b0011},  // R8
    '{2'b11, 1'b0, 7'h20, 3'b101, 4'b0100},  // R8
    '{2'b11, 1'b0, 7'h11, 3'b100, 4'b1111}   // R8
  };

  function automatic logic [3:0] ref_op(logic [1:0] c, logic i, logic [6:0] s7, logic [2:0] s3);
    logic [3:0] base;
    if (c == 2'b01) return 4'b0010;
    case (s3)
      3'b000: base = 4'b0010;
      3'b001: base = 4'b1001;
      3'b010: base = 4'b1000;
      3'b011: base = 4'b0101;
      3'b100: base = 4'b0110;
      3'b101: base = 4'b0111;
      3'b110: base = 4'b0001;
      default: base = 4'b0000;
    endcase
    if (i) return (s3 == 3'b101 && s7[5]) ? 4'b0100 : base;
    if (s7 == 7'h00) return base;
    if (s7 == 7'h20) begin
      if (s3 == 3'b000) return 4'b0011;
      if (s3 == 3'b101) return 4'b0100;
    end
    return 4'b1111;
  endfunction

  function automatic string req_of(logic [1:0] c, logic i, logic [6:0] s7, logic [2:0] s3);
    string p;
    p = (c[1]) ? "R8/" : "";
    if (c == 2'b01) return "R1";
    if (i) return {p, (s3 == 3'b101) ? "R7" : "R6"};
    if (s7 != 7'h00 && !(s7 == 7'h20 && (s3 == 3'b000 || s3 == 3'b101))) return {p, "R5"};
    if (s3 == 3'b000) return {p, "R3"};
    if (s3 == 3'b101) return {p, "R4"};
    return {p, "R2"};
  endfunction

  task automatic apply(logic [1:0] c, logic i, logic [6:0] s7, logic [2:0] s3,
                       logic [3:0] e, string req);
    @(posedge clk);
    cls = c; imm = i; f7 = s7; f3 = s3;
    @(negedge clk);
    n_chk++;
    if (op !== e) begin
      n_fail++;
      $display("FAIL %s cls=%b imm=%b f7=%b f3=%b got %b expected %b",
               req, c, i, s7, s3, op, e);
    end
  endtask

  initial begin
    cls = '0; imm = 1'b0; f7 = '0; f3 = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // quiescent all-zero inputs decode to add: R2/R3 base case
    @(negedge clk);
    n_chk++;
    if (op !== 4'b0010) begin
      n_fail++;
      $display("FAIL R3 idle inputs got %b expected 0010", op);
    end

    for (int k = 0; k < NV; k++)
      apply(VECS[k].c, VECS[k].i, VECS[k].s7, VECS[k].s3, VECS[k].e,
            req_of(VECS[k].c, VECS[k].i, VECS[k].s7, VECS[k].s3));

    // R6 R7: funct7 walking one under immediate flag, every funct3
    for (int b = 0; b < 7; b++)
      for (int s = 0; s < 8; s++)
        apply(2'b00, 1'b1, 7'(1 << b), 3'(s),
              ref_op(2'b00, 1'b1, 7'(1 << b), 3'(s)), (s == 5) ? "R7" : "R6");

    // full sweep; R9 covered by every compare
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 2; i++)
        for (int s7 = 0; s7 < 128; s7++)
          for (int s3 = 0; s3 < 8; s3++)
            apply(2'(c), 1'(i), 7'(s7), 3'(s3),
                  ref_op(2'(c), 1'(i), 7'(s7), 3'(s3)),
                  req_of(2'(c), 1'(i), 7'(s7), 3'(s3)));

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WDOG_LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule